// File: doc/BRIEF.md
# Multichannel ADC scan controller

This block is a byte-wide register file on a small host bus that drives an external analog-to-digital converter. The host chooses a window of channels with a low and a high channel register, sets the front-end gain and range through a configuration register, and then starts work. A start comes either from a write to offset 0 or from one of two scan clock ticks. Without scan mode, one start gives one conversion on the low channel. With scan mode, one start walks every channel from low to high, counting upward and wrapping from 31 to 0.

Each result is 16 bits. With the FIFO enabled, results queue in a small FIFO and the host reads them a byte at a time. Reading the high byte removes the entry. With the FIFO disabled, a holding register keeps the last result. At the end of a scan (or of a single conversion) the block raises its interrupt line if the host enabled it. A control write clears the interrupt, and another control bit resets the block to its initial state.

A settling flag in the configuration readback rises after every change to the channel window or to the configuration. It lets the host wait for the analog path to settle.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The low channel register (offset 0x2) and the high channel register (offset 0x3) keep only bits 4:0, so writing 0x80 reads back 0x00 and writing 0xFF reads back 0x1F. After reset they read 0x00 and 0x1F.
- R2: When software start is selected, a write of any value to offset 0x0 pulses adc_start for one cycle, starting on the clock edge after the write. adc_chan shows the low channel during that pulse. Each adc_done pulse ends that conversion.
- R3: With scan enable (bit 2 of offset 0x7) set, one start converts channels low, low+1, and so on up to high, modulo 32. There is one adc_start per channel, issued in that order.
- R4: With FIFO enable (bit 3 of offset 0x7) set, each result enters the FIFO. Offset 0x0 reads the low byte of the oldest entry. A read strobe at offset 0x1 returns the high byte and removes the entry. A result that arrives while the FIFO is full, with no removal in the same cycle, is dropped and sets the overflow flag. Writing bit 1 of offset 0x7 empties the FIFO and clears overflow.
- R5: With the FIFO disabled, offsets 0x0 and 0x1 read the low and high bytes of the most recent result, and reading them changes nothing.
- R6: Offset 0xB holds the scan interval in bits 5:4 (driven on scan_interval), the range in bit 3, unipolar select in bit 2 and gain in bits 1:0. Bits 3:0 drive ana_cfg. A read returns {settling flag, 000, bits 3:0}, so writing 0x0C reads 0x0C once settling ends.
- R7: The settling flag (bit 7 of an offset 0xB read) is high for exactly SETTLE_CYC cycles after any write to offset 0x2, 0x3 or 0xB.
- R8: irq goes high when a scan (or a single conversion) completes while the interrupt enable (bit 7 of offset 0x9) is set. A write to offset 0x8 with bit 3 set clears irq. If a completion and a clear fall in the same cycle, the completion wins.
- R9: When bit 1 of offset 0x9 is set, starts come only from a tick: tick_int if bit 0 is 1, tick_ext if bit 0 is 0. Writes to offset 0x0 then start nothing.
- R10: A write to offset 0x8 with bit 5 set aborts any conversion sequence and clears offsets 0x7 and 0x9 and irq. It also empties the FIFO and returns the channel registers to 0x00 and 0x1F.
- R11: Offset 0x7 reads {empty, at least half full, full, overflow, FIFO enable, scan enable, page}, where page is bits 1:0 of the last write to offset 0x8. Offset 0x8 reads {busy, 1, 1, current channel} when SINGLE_ENDED is set.
- R12: A start that arrives while a conversion sequence is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (removes a FIFO entry at offset 0x1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tick_int | input | 1 | Scan tick from the internal timer |
| tick_ext | input | 1 | Scan tick from an external clock |
| adc_start | output | 1 | One-cycle conversion start |
| adc_chan | output | 5 | Channel to convert |
| adc_done | input | 1 | One-cycle conversion done |
| adc_data | input | 16 | Conversion result, valid with adc_done |
| ana_cfg | output | 4 | Range, unipolar and gain setting |
| scan_interval | output | 2 | Scan interval code |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a result entering a full FIFO and a host read that removes an entry. The bench fills the FIFO with an eight-channel scan and then starts a single conversion. It waits for the cycle in which adc_done is high and asserts the removing read in that same cycle. It then requires the FIFO to stay full with no overflow, and requires a drain to return the seven older entries followed by the new one, in order.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam logic [3:0] OFS_RES_LO = 4'h0;
   localparam logic [3:0] OFS_RES_HI = 4'h1;
   localparam logic [3:0] OFS_CH_LO  = 4'h2;
   localparam logic [3:0] OFS_CH_HI  = 4'h3;
   localparam logic [3:0] OFS_FIFO   = 4'h7;
   localparam logic [3:0] OFS_CTRL   = 4'h8;
   localparam logic [3:0] OFS_INTCLK = 4'h9;
   localparam logic [3:0] OFS_CFG    = 4'hB;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_FIRE = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_t;
endpackage

// File: rtl/adc_scan_settle.sv
module adc_scan_settle #(
   parameter int unsigned CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic waiting
);
   localparam int unsigned CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt;

   initial begin
      if (CYC < 1) $fatal(1, "settle window must be at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (kick)        cnt <= CW'(CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign waiting = (cnt != '0);

   // R7: a write to a watched register always raises the flag next cycle
   p_kick_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> waiting);
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         half,
   output logic         full,
   output logic         ovf
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

   logic [DEPTH-1:0][W-1:0] slots;
   logic [AW-1:0]           wp, rp;
   logic [AW:0]             cnt;
   logic                    do_pop, do_push;

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "FIFO depth must be a power of two, at least 2");
   end

   assign do_pop  = pop && (cnt != '0);
   assign do_push = push && ((cnt != FULL_CNT) || do_pop);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (do_push && wp == AW'(i))    q <= din;
         end
         assign slots[i] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
      end else if (clr) begin
         wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   assign dout  = slots[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_CNT);
   assign half  = (cnt >= HALF_CNT);

   // R4: a result into a full FIFO with no removal is dropped and flagged
   p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (full && ovf));
   // R4: removing from an empty FIFO leaves it empty
   p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !clr) |=> empty);
   // R4: a result and a removal together on a full FIFO keep it full, no overflow
   p_push_pop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && pop && !clr) |=> (full && ovf == $past(ovf)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int unsigned CHAN_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              go,
   input  logic              scan_en,
   input  logic [CHAN_W-1:0] lo_chan,
   input  logic [CHAN_W-1:0] hi_chan,
   input  logic              adc_done,
   output logic              adc_start,
   output logic              busy,
   output logic              res_valid,
   output logic              scan_done,
   output logic [CHAN_W-1:0] chan
);
   seq_state_t st;
   logic       last;

   assign last      = !scan_en || (chan == hi_chan);
   assign res_valid = (st == SQ_WAIT) && adc_done;
   assign scan_done = res_valid && last;
   assign adc_start = (st == SQ_FIRE);
   assign busy      = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         chan <= '0;
      end else if (abort) begin
         st <= SQ_IDLE;
      end else begin
         case (st)
            SQ_IDLE: if (go) begin
               chan <= lo_chan;
               st   <= SQ_FIRE;
            end
            SQ_FIRE: st <= SQ_WAIT;
            SQ_WAIT: if (adc_done) begin
               if (last) st <= SQ_IDLE;
               else begin
                  chan <= chan + 1'b1;
                  st   <= SQ_FIRE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // R2: a start while idle fires the converter on the low channel
   p_go_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go && !abort) |=> (adc_start && chan == $past(lo_chan)));
   // R3: a result that is not the last steps to the next channel, modulo 32
   p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !last && !abort) |=> (adc_start && chan == CHAN_W'($past(chan) + 1'b1)));
   // R12: while busy and without a result, the channel does not move
   p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res_valid && !abort) |=> (chan == $past(chan)));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int unsigned CHAN_W       = 5,
   parameter int unsigned RES_W        = 16,
   parameter int unsigned FIFO_DEPTH   = 8,
   parameter int unsigned SETTLE_CYC   = 16,
   parameter bit          SINGLE_ENDED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              tick_int,
   input  logic              tick_ext,
   output logic              adc_start,
   output logic [CHAN_W-1:0] adc_chan,
   input  logic              adc_done,
   input  logic [RES_W-1:0]  adc_data,
   output logic [3:0]        ana_cfg,
   output logic [1:0]        scan_interval,
   output logic              irq
);
   localparam int unsigned STAT_CW = 5;

   initial begin
      if (CHAN_W < 1 || CHAN_W > STAT_CW) $fatal(1, "channel width must be 1 to 5");
      if (RES_W != 16) $fatal(1, "result must be two bytes wide");
   end

   logic [CHAN_W-1:0] lo_q, hi_q, cur_chan;
   logic [5:0]        cfg_q;
   logic              fifo_en_q, scan_en_q, ien_q, tick_mode_q, clk_sel_q;
   logic [1:0]        page_q;
   logic [RES_W-1:0]  hold_q, fifo_dout;
   logic              fifo_empty, fifo_half, fifo_full, fifo_ovf;
   logic              busy, res_valid, scan_done, settling;
   logic [1:0]        mode_bits;

   logic wr_start, wr_lo, wr_hi, wr_fifo, wr_ctrl, wr_intclk, wr_cfg;
   logic soft_rst, go, fifo_clr, fifo_pop;
   logic unused_wbits;

   assign unused_wbits = bus_wdata[6];

   assign wr_start  = bus_wr && bus_addr == OFS_RES_LO;
   assign wr_lo     = bus_wr && bus_addr == OFS_CH_LO;
   assign wr_hi     = bus_wr && bus_addr == OFS_CH_HI;
   assign wr_fifo   = bus_wr && bus_addr == OFS_FIFO;
   assign wr_ctrl   = bus_wr && bus_addr == OFS_CTRL;
   assign wr_intclk = bus_wr && bus_addr == OFS_INTCLK;
   assign wr_cfg    = bus_wr && bus_addr == OFS_CFG;
   assign soft_rst  = wr_ctrl && bus_wdata[5];

   assign go       = tick_mode_q ? (clk_sel_q ? tick_int : tick_ext) : wr_start;
   assign fifo_clr = soft_rst || (wr_fifo && bus_wdata[1]);
   assign fifo_pop = bus_rd && bus_addr == OFS_RES_HI && fifo_en_q;

   generate
      if (SINGLE_ENDED) begin : g_se
         assign mode_bits = 2'b11;
      end else begin : g_diff
         assign mode_bits = 2'b00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0; hi_q <= '1; cfg_q <= '0;
         fifo_en_q <= 1'b0; scan_en_q <= 1'b0;
         ien_q <= 1'b0; tick_mode_q <= 1'b0; clk_sel_q <= 1'b0;
         page_q <= '0; irq <= 1'b0; hold_q <= '0;
      end else begin
         if (wr_lo)  lo_q  <= bus_wdata[CHAN_W-1:0];
         if (wr_hi)  hi_q  <= bus_wdata[CHAN_W-1:0];
         if (wr_cfg) cfg_q <= bus_wdata[5:0];
         if (wr_fifo) begin
            fifo_en_q <= bus_wdata[3];
            scan_en_q <= bus_wdata[2];
         end
         if (wr_intclk) begin
            ien_q       <= bus_wdata[7];
            tick_mode_q <= bus_wdata[1];
            clk_sel_q   <= bus_wdata[0];
         end
         if (wr_ctrl) page_q <= bus_wdata[1:0];
         if (soft_rst) begin
            lo_q <= '0; hi_q <= '1;
            fifo_en_q <= 1'b0; scan_en_q <= 1'b0;
            ien_q <= 1'b0; tick_mode_q <= 1'b0; clk_sel_q <= 1'b0;
         end
         if (soft_rst)                    irq <= 1'b0;
         else if (scan_done && ien_q)     irq <= 1'b1;
         else if (wr_ctrl && bus_wdata[3]) irq <= 1'b0;
         if (res_valid && !fifo_en_q) hold_q <= adc_data;
      end
   end

   adc_scan_seq #(.CHAN_W(CHAN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst), .go(go), .scan_en(scan_en_q),
      .lo_chan(lo_q), .hi_chan(hi_q), .adc_done(adc_done), .adc_start(adc_start),
      .busy(busy), .res_valid(res_valid), .scan_done(scan_done), .chan(cur_chan)
   );

   adc_scan_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(res_valid && fifo_en_q),
      .din(adc_data), .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty),
      .half(fifo_half), .full(fifo_full), .ovf(fifo_ovf)
   );

   adc_scan_settle #(.CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .kick(wr_lo || wr_hi || wr_cfg), .waiting(settling)
   );

   always_comb begin
      case (bus_addr)
         OFS_RES_LO: bus_rdata = fifo_en_q ? fifo_dout[7:0]  : hold_q[7:0];
         OFS_RES_HI: bus_rdata = fifo_en_q ? fifo_dout[15:8] : hold_q[15:8];
         OFS_CH_LO:  bus_rdata = 8'(lo_q);
         OFS_CH_HI:  bus_rdata = 8'(hi_q);
         OFS_FIFO:   bus_rdata = {fifo_empty, fifo_half, fifo_full, fifo_ovf,
                                  fifo_en_q, scan_en_q, page_q};
         OFS_CTRL:   bus_rdata = {busy, mode_bits, STAT_CW'(cur_chan)};
         OFS_INTCLK: bus_rdata = {ien_q, 5'b0, tick_mode_q, clk_sel_q};
         OFS_CFG:    bus_rdata = {settling, 3'b0, cfg_q[3:0]};
         default:    bus_rdata = 8'h00;
      endcase
   end

   assign adc_chan      = cur_chan;
   assign ana_cfg       = cfg_q[3:0];
   assign scan_interval = cfg_q[5:4];

   // R8: the interrupt only rises while enabled
   p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ien_q));
   // R8: a clear with no completion in the same cycle drops the line
   p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[3] && !scan_done) |=> !irq);
   // R10: a soft reset restores the channel window and the control registers
   p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (hi_q == '1 && lo_q == '0 && !fifo_en_q && !ien_q && !irq && !busy));
endmodule

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
   localparam int SETTLE = 12;
   localparam int DEPTH  = 8;
   localparam int LAT    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        tick_int = 1'b0, tick_ext = 1'b0;
   logic        adc_start;
   logic [4:0]  adc_chan;
   logic        adc_done = 1'b0;
   logic [15:0] adc_data = '0;
   logic [3:0]  ana_cfg;
   logic [1:0]  scan_interval;
   logic        irq;

   int total = 0, bad = 0;
   int n_start = 0, n_conv = 0;
   logic [4:0]  log_chan [1024];
   logic [15:0] log_val  [1024];
   logic        pend = 1'b0;
   int          pcnt = 0;
   logic [4:0]  pchan = '0;
   logic [1:0]  pg = 2'd0;

   always #2 clk = ~clk;

   adc_scan_ctrl #(.FIFO_DEPTH(DEPTH), .SETTLE_CYC(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_int(tick_int), .tick_ext(tick_ext),
      .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data),
      .ana_cfg(ana_cfg), .scan_interval(scan_interval), .irq(irq)
   );

   function automatic logic [15:0] mk_val(logic [4:0] ch, int n);
      return {ch, 11'(n * 13 + 5)};
   endfunction

   function automatic logic [4:0] chan_at(logic [4:0] lo, int i);
      return 5'(int'(lo) + i);
   endfunction

   // converter model: answers each start after LAT idle cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0; adc_done <= 1'b0;
      end else begin
         adc_done <= 1'b0;
         if (pend && pcnt == 0) begin
            adc_done <= 1'b1;
            adc_data <= mk_val(pchan, n_conv);
            log_val[n_conv] <= mk_val(pchan, n_conv);
            n_conv <= n_conv + 1;
            pend <= 1'b0;
         end else if (pend) pcnt <= pcnt - 1;
         if (adc_start) begin
            pend <= 1'b1; pcnt <= LAT; pchan <= adc_chan;
            log_chan[n_start] <= adc_chan;
            n_start <= n_start + 1;
         end
      end
   end

   task automatic chk(input string rq, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_res(output logic [15:0] v);
      logic [7:0] l, h;
      rd(4'h0, l);
      rd(4'h1, h);
      v = {h, l};
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int k = 0; k < 200; k++) begin
         rd(4'h8, s);
         if (!s[7]) break;
      end
   endtask

   task automatic pulse(input bit sel_int);
      @(negedge clk);
      if (sel_int) tick_int = 1'b1; else tick_ext = 1'b1;
      @(negedge clk);
      tick_int = 1'b0; tick_ext = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [15:0] r;
      int s0, c0;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(4'h2, v); chk("R1", "reset low chan", v, 8'h00);
      rd(4'h3, v); chk("R1", "reset high chan", v, 8'h1F);
      rd(4'h7, v); chk("R11", "reset fifo status", v, 8'h80);
      rd(4'h8, v); chk("R11", "reset status", v, 8'h60);
      rd(4'h9, v); chk("R10", "reset intclk", v, 8'h00);
      rd(4'hB, v); chk("R6", "reset cfg", v, 8'h00);
      chk("R8", "reset irq", irq, 0);

      // R1 channel width
      wr(4'h2, 8'h80); rd(4'h2, v); chk("R1", "low keeps 5 bits", v, 8'h00);
      wr(4'h3, 8'hFF); rd(4'h3, v); chk("R1", "high keeps 5 bits", v, 8'h1F);

      // R6 / R7 configuration and exact settling window
      wr(4'hB, 8'h3F);
      bus_addr = 4'hB;
      #1 chk("R7", "settle first cycle", bus_rdata[7], 1);
      repeat (SETTLE - 1) @(negedge clk);
      #1 chk("R7", "settle last cycle", bus_rdata[7], 1);
      @(negedge clk);
      #1 chk("R7", "settle ends", bus_rdata[7], 0);
      rd(4'hB, v); chk("R6", "cfg readback 0x3F", v, 8'h0F);
      chk("R6", "ana_cfg", ana_cfg, 4'hF);
      chk("R6", "scan_interval", scan_interval, 2'd3);
      wr(4'hB, 8'h0C);
      rd(4'hB, v); chk("R7", "settling after cfg write", v, 8'h8C);
      repeat (SETTLE + 2) @(negedge clk);
      rd(4'hB, v); chk("R6", "cfg readback settled", v, 8'h0C);
      chk("R6", "scan_interval zero", scan_interval, 2'd0);
      wr(4'h2, 8'h05);
      rd(4'hB, v); chk("R7", "settling after channel write", v[7], 1);

      // R2 / R5 / R11 / R12 single conversion, hold register
      s0 = n_start; c0 = n_conv;
      wr(4'h0, 8'h5A);
      wr(4'h0, 8'hA5);
      rd(4'h8, v); chk("R11", "busy status with channel", v, 8'hE5);
      wait_idle();
      chk("R12", "one start while busy", n_start - s0, 1);
      chk("R2", "channel converted", log_chan[s0], 5);
      rd_res(r); chk("R5", "hold result", r, log_val[c0]);
      rd_res(r); chk("R5", "hold result unchanged", r, log_val[c0]);
      chk("R8", "no irq when disabled", irq, 0);

      // R3 / R4 scan with wrap and half-full flag
      wr(4'h2, 8'd30); wr(4'h3, 8'd1); wr(4'h7, 8'h0E);
      s0 = n_start; c0 = n_conv;
      wr(4'h0, 8'h00);
      wait_idle();
      chk("R3", "scan length", n_start - s0, 4);
      for (int i = 0; i < 4; i++) chk("R3", "scan order", log_chan[s0 + i], chan_at(5'd30, i));
      rd(4'h7, v); chk("R11", "fifo half", v, 8'h4C);
      for (int i = 0; i < 4; i++) begin
         rd_res(r); chk("R4", "fifo entry", r, log_val[c0 + i]);
      end
      rd(4'h7, v); chk("R4", "fifo empty after drain", v, 8'h8C);

      // R4 overflow then FIFO reset
      wr(4'h2, 8'd0); wr(4'h3, 8'd9);
      c0 = n_conv;
      wr(4'h0, 8'h00);
      wait_idle();
      rd(4'h7, v); chk("R4", "full with overflow", v, 8'h7C);
      for (int i = 0; i < DEPTH; i++) begin
         rd_res(r); chk("R4", "kept entry", r, log_val[c0 + i]);
      end
      rd(4'h7, v); chk("R4", "empty overflow sticky", v, 8'h9C);
      wr(4'h7, 8'h0E);
      rd(4'h7, v); chk("R4", "fifo reset clears overflow", v, 8'h8C);

      // R4 push and pop in the same cycle on a full FIFO
      wr(4'h3, 8'd7);
      c0 = n_conv;
      wr(4'h0, 8'h00);
      wait_idle();
      rd(4'h7, v); chk("R4", "filled", v, 8'h6C);
      wr(4'h7, 8'h08); wr(4'h2, 8'd12);
      wr(4'h0, 8'h00);
      for (int k = 0; k < 50; k++) begin
         @(negedge clk); #1;
         if (adc_done) break;
      end
      bus_addr = 4'h1; bus_rd = 1'b1;
      #1 chk("R4", "pop at collision", bus_rdata, 8'(log_val[c0] >> 8));
      @(negedge clk); bus_rd = 1'b0;
      wait_idle();
      rd(4'h7, v); chk("R4", "collision keeps full no overflow", v, 8'h68);
      for (int i = 1; i <= DEPTH; i++) begin
         rd_res(r); chk("R4", "order after collision", r, log_val[c0 + i]);
      end

      // R11 page bits
      wr(4'h8, 8'h03); pg = 2'd3;
      rd(4'h7, v); chk("R11", "page readback", v[1:0], pg);

      // R8 interrupt set and clear
      wr(4'h8, 8'h20); pg = 2'd0;
      wr(4'h9, 8'h80); wr(4'h2, 8'd7);
      wr(4'h0, 8'h00);
      wait_idle();
      chk("R8", "irq on completion", irq, 1);
      wr(4'h8, 8'h08);
      chk("R8", "irq cleared", irq, 0);

      // R9 tick start
      wr(4'h8, 8'h20);
      wr(4'h2, 8'd3); wr(4'h9, 8'h02);
      s0 = n_start;
      wr(4'h0, 8'h00);
      repeat (10) @(negedge clk);
      chk("R9", "software start ignored", n_start - s0, 0);
      pulse(1'b1);
      repeat (10) @(negedge clk);
      chk("R9", "unselected tick ignored", n_start - s0, 0);
      pulse(1'b0);
      wait_idle();
      chk("R9", "ext tick starts", n_start - s0, 1);
      chk("R9", "tick channel", log_chan[s0], 3);
      wr(4'h9, 8'h03);
      pulse(1'b1);
      wait_idle();
      chk("R9", "int tick starts", n_start - s0, 2);

      // R10 soft reset
      wr(4'h3, 8'd4); wr(4'h7, 8'h0C); wr(4'h9, 8'h80);
      wr(4'h8, 8'h20);
      rd(4'h7, v); chk("R10", "fifo ctrl cleared", v, 8'h80);
      rd(4'h9, v); chk("R10", "intclk cleared", v, 8'h00);
      rd(4'h2, v); chk("R10", "low chan reset", v, 8'h00);
      rd(4'h3, v); chk("R10", "high chan reset", v, 8'h1F);

      // random scans
      for (int it = 0; it < 16; it++) begin
         logic [4:0] lo, hi;
         int span;
         lo = 5'($urandom % 32);
         span = 1 + int'($urandom % 8);
         hi = chan_at(lo, span - 1);
         wr(4'h2, 8'(lo)); wr(4'h3, 8'(hi)); wr(4'h7, 8'h0E);
         s0 = n_start; c0 = n_conv;
         wr(4'h0, 8'($urandom));
         wait_idle();
         chk("R3", "random scan length", n_start - s0, span);
         for (int i = 0; i < span; i++) begin
            chk("R3", "random scan order", log_chan[s0 + i], chan_at(lo, i));
            rd_res(r); chk("R4", "random fifo entry", r, log_val[c0 + i]);
         end
         rd(4'h7, v); chk("R4", "random drained", v[7], 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule